// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects eight interrupt request lines, ranks them by a fixed priority and raises one interrupt line toward a processor. Software programs it through a narrow register port: a one-bit address, a write strobe, a read strobe and a byte of data in each direction. The block can only be used after an initialization sequence. That sequence sets the trigger style (edge or level), the upper bits of the interrupt vector and whether in-service bits clear themselves. Once the sequence is complete, command writes mask inputs, retire serviced interrupts, choose which status register a read returns, and arm a poll read.

When the processor acknowledges, the block returns an 8-bit vector on the same cycle. That vector is the programmed base with the winning level in its low three bits. The same edge records the level as in service. A poll read gives the processor another way to take an interrupt: it returns a pending flag and the winning level, and it accepts that level the same way an acknowledge does. Cascading several controllers, priority rotation, special masking and buffered-mode pin control are not implemented. Any control bits that request them are ignored.

Top module: `intc8`

## Requirements
- R1: A write at address 0 with data bit 4 set restarts initialization from any state. It clears the mask, the in-service bits, the latched edges, the read selection (back to requests) and any armed poll. Until the sequence completes, the interrupt output stays low and writes to the mask or command words have no effect.
- R2: After the restart word, writes at address 1 are taken in order as the vector word, the cascade word, then the options word. Restart-word bit 1 = 1 skips the cascade word. Restart-word bit 0 = 0 skips the options word, and its fields then read as zero. The block becomes operational after the last word the sequence requires.
- R3: Bits 7:3 of the vector word form the vector base. On an acknowledge, `vec` equals that base with the winning level in bits 2:0. With no winner, the low bits are 7 and no state changes.
- R4: Priority is fixed, with input 0 the highest. The interrupt output is high only when an unmasked request has a lower index than every set in-service bit.
- R5: An acknowledge or a poll read accepts the winning level and clears its latched edge. It also sets that level's in-service bit, unless options-word bit 1 (automatic end of interrupt) is set, in which case the in-service bits are left unchanged.
- R6: Once operational, address 1 reads and writes the 8-bit mask. Mask bit n set blocks input n.
- R7: A write at address 0 with bits 4 and 3 clear and bit 5 set is an end-of-interrupt. If bit 6 is set, it clears the in-service bit given by bits 2:0. Otherwise it clears the lowest-index set in-service bit. With bit 5 clear, the write has no effect.
- R8: Restart-word bit 3 = 1 selects level triggering, where the request register follows the inputs. With bit 3 = 0, a rising input edge latches a request that stays until it is accepted, even if the input stays high.
- R9: A write at address 0 with bit 4 clear and bit 3 set is a read-control word. If bit 1 is set, bit 0 chooses what later reads at address 0 return: in-service register (1) or request register (0). If bit 1 is clear, the choice is kept.
- R10: If bit 2 of the read-control word is set, the next read at address 0 returns bit 7 = interrupt pending, bits 6:3 = 0 and bits 2:0 = the winning level (0 when nothing is pending), and it accepts that level. Later reads return the selected register again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | Register address |
| wr | input | 1 | Write strobe, one cycle per write |
| rd | input | 1 | Read strobe, one cycle per read |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, valid while rd is high |
| req_in | input | 8 | Interrupt request inputs |
| int_out | output | 1 | Interrupt to the processor |
| ack | input | 1 | Acknowledge strobe, one cycle |
| vec | output | 8 | Vector, valid while ack is high |

## Verification
A wrong in-service bit shows up at once on `int_out`. A stale bit holds back lower levels, and a missing bit lets a lower level through on the next cycle. A wrong bit is also visible on the next status read. A wrong sequencer state changes which address-1 write reaches the mask, and this is seen the first time the mask is read back. A latched edge that is not cleared makes `int_out` come back right after an acknowledge, even though the input never rose again. Every check is made at the ports, within one or two cycles of the stimulus that caused it.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int INTC_N  = 8;
    localparam int INTC_DW = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VEC,
        ST_CASC,
        ST_OPT,
        ST_RUN
    } init_st_e;

endpackage

// File: rtl/intc_seq.sv
module intc_seq
    import intc_pkg::*;
#(
    parameter int DW = INTC_DW,
    parameter int LW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr,
    input  logic             wr,
    input  logic             rd,
    input  logic [DW-1:0]    din,
    output logic             ready,
    output logic             lvl_trig,
    output logic             auto_eoi,
    output logic             show_isr,
    output logic             poll_arm,
    output logic [DW-LW-1:0] base,
    output logic             restart,
    output logic             mask_we,
    output logic             eoi_sp,
    output logic             eoi_ns,
    output logic             poll_take
);

    localparam int BW = DW - LW;

    typedef struct packed {
        init_st_e        st;
        logic            want_opt;
        logic            solo;
        logic            lvl_trig;
        logic            auto_eoi;
        logic            show_isr;
        logic            poll_arm;
        logic [BW-1:0]   base;
    } seq_t;

    seq_t seq_d, seq_q;

    logic run;
    logic cmd_wr;
    logic eoi_wr;
    logic rdctl_wr;

    always_comb begin
        run       = (seq_q.st == ST_RUN);
        restart   = wr && !addr && din[4];
        cmd_wr    = wr && !addr && !din[4] && run;
        eoi_wr    = cmd_wr && !din[3] && din[5];
        rdctl_wr  = cmd_wr && din[3];
        eoi_sp    = eoi_wr && din[6];
        eoi_ns    = eoi_wr && !din[6];
        mask_we   = wr && addr && run;
        poll_take = rd && !addr && run && seq_q.poll_arm;

        seq_d = seq_q;
        if (restart) begin
            seq_d.st       = ST_VEC;
            seq_d.want_opt = din[0];
            seq_d.solo     = din[1];
            seq_d.lvl_trig = din[3];
            seq_d.auto_eoi = 1'b0;
            seq_d.show_isr = 1'b0;
            seq_d.poll_arm = 1'b0;
        end else if (wr && addr) begin
            case (seq_q.st)
                ST_VEC: begin
                    seq_d.base = din[DW-1:LW];
                    if (!seq_q.solo)
                        seq_d.st = ST_CASC;
                    else if (seq_q.want_opt)
                        seq_d.st = ST_OPT;
                    else
                        seq_d.st = ST_RUN;
                end
                ST_CASC: begin
                    seq_d.st = seq_q.want_opt ? ST_OPT : ST_RUN;
                end
                ST_OPT: begin
                    seq_d.auto_eoi = din[1];
                    seq_d.st       = ST_RUN;
                end
                default: seq_d.st = seq_q.st;
            endcase
        end

        if (rdctl_wr) begin
            if (din[1])
                seq_d.show_isr = din[0];
            if (din[2])
                seq_d.poll_arm = 1'b1;
        end
        if (poll_take)
            seq_d.poll_arm = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, base: '0, default: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ready    = run;
    assign lvl_trig = seq_q.lvl_trig;
    assign auto_eoi = seq_q.auto_eoi;
    assign show_isr = seq_q.show_isr;
    assign poll_arm = seq_q.poll_arm;
    assign base     = seq_q.base;

endmodule

// File: rtl/intc_prio.sv
module intc_prio
    import intc_pkg::*;
#(
    parameter int N  = INTC_N,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  irr,
    input  logic [N-1:0]  mask,
    input  logic [N-1:0]  isr,
    output logic          win_valid,
    output logic [LW-1:0] win_lvl,
    output logic          isr_any,
    output logic [LW-1:0] isr_lvl
);

    logic [N-1:0] cand;

    for (genvar i = 0; i < N; i++) begin : g_cand
        assign cand[i] = irr[i] && !mask[i] && !(|isr[i:0]);
    end

    always_comb begin
        win_valid = 1'b0;
        win_lvl   = '0;
        isr_any   = 1'b0;
        isr_lvl   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                win_valid = 1'b1;
                win_lvl   = LW'(i);
            end
            if (isr[i]) begin
                isr_any = 1'b1;
                isr_lvl = LW'(i);
            end
        end
    end

endmodule

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int N  = INTC_N,
    parameter int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_in,
    input  logic          lvl_trig,
    input  logic          auto_eoi,
    input  logic          restart,
    input  logic          mask_we,
    input  logic [N-1:0]  mask_wdata,
    input  logic          eoi_en,
    input  logic [LW-1:0] eoi_lvl,
    input  logic          take,
    input  logic [LW-1:0] take_lvl,
    output logic [N-1:0]  irr,
    output logic [N-1:0]  isr,
    output logic [N-1:0]  mask
);

    typedef struct packed {
        logic [N-1:0] edge_lat;
        logic [N-1:0] prev;
        logic [N-1:0] isr;
        logic [N-1:0] mask;
    } core_t;

    core_t core_d, core_q;

    always_comb begin
        core_d          = core_q;
        core_d.prev     = req_in;
        core_d.edge_lat = core_q.edge_lat | (req_in & ~core_q.prev);

        if (mask_we)
            core_d.mask = mask_wdata;
        if (eoi_en)
            core_d.isr[eoi_lvl] = 1'b0;
        if (take) begin
            core_d.edge_lat[take_lvl] = 1'b0;
            if (!auto_eoi)
                core_d.isr[take_lvl] = 1'b1;
        end
        if (restart) begin
            core_d.edge_lat = '0;
            core_d.isr      = '0;
            core_d.mask     = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign irr  = lvl_trig ? req_in : core_q.edge_lat;
    assign isr  = core_q.isr;
    assign mask = core_q.mask;

endmodule

// File: rtl/intc8.sv
module intc8
    import intc_pkg::*;
#(
    parameter int N  = INTC_N,
    parameter int DW = INTC_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr,
    input  logic          wr,
    input  logic          rd,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    input  logic [N-1:0]  req_in,
    output logic          int_out,
    input  logic          ack,
    output logic [DW-1:0] vec
);

    localparam int LW = $clog2(N);
    localparam int BW = DW - LW;
    localparam int PZ = DW - 1 - LW;

    logic          ready_w;
    logic          lvl_trig_w;
    logic          auto_eoi_w;
    logic          show_isr_w;
    logic          poll_arm_w;
    logic [BW-1:0] base_w;
    logic          restart_w;
    logic          mask_we_w;
    logic          eoi_sp_w;
    logic          eoi_ns_w;
    logic          poll_take_w;

    logic [N-1:0]  irr_w;
    logic [N-1:0]  isr_w;
    logic [N-1:0]  mask_w;

    logic          win_valid_w;
    logic [LW-1:0] win_lvl_w;
    logic          isr_any_w;
    logic [LW-1:0] isr_lvl_w;

    logic          eoi_en_w;
    logic [LW-1:0] eoi_lvl_w;
    logic          take_w;
    logic [DW-1:0] poll_byte_w;

    intc_seq #(
        .DW (DW),
        .LW (LW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wr        (wr),
        .rd        (rd),
        .din       (din),
        .ready     (ready_w),
        .lvl_trig  (lvl_trig_w),
        .auto_eoi  (auto_eoi_w),
        .show_isr  (show_isr_w),
        .poll_arm  (poll_arm_w),
        .base      (base_w),
        .restart   (restart_w),
        .mask_we   (mask_we_w),
        .eoi_sp    (eoi_sp_w),
        .eoi_ns    (eoi_ns_w),
        .poll_take (poll_take_w)
    );

    intc_prio #(
        .N  (N),
        .LW (LW)
    ) u_prio (
        .irr       (irr_w),
        .mask      (mask_w),
        .isr       (isr_w),
        .win_valid (win_valid_w),
        .win_lvl   (win_lvl_w),
        .isr_any   (isr_any_w),
        .isr_lvl   (isr_lvl_w)
    );

    always_comb begin
        int_out     = ready_w && win_valid_w;
        take_w      = (ack || poll_take_w) && int_out;
        eoi_en_w    = eoi_sp_w || (eoi_ns_w && isr_any_w);
        eoi_lvl_w   = eoi_sp_w ? din[LW-1:0] : isr_lvl_w;
        vec         = {base_w, int_out ? win_lvl_w : {LW{1'b1}}};
        poll_byte_w = {int_out, {PZ{1'b0}}, int_out ? win_lvl_w : {LW{1'b0}}};
        if (addr)
            dout = DW'(mask_w);
        else if (poll_arm_w)
            dout = poll_byte_w;
        else if (show_isr_w)
            dout = DW'(isr_w);
        else
            dout = DW'(irr_w);
    end

    intc_regs #(
        .N  (N),
        .LW (LW)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_in     (req_in),
        .lvl_trig   (lvl_trig_w),
        .auto_eoi   (auto_eoi_w),
        .restart    (restart_w),
        .mask_we    (mask_we_w),
        .mask_wdata (din[N-1:0]),
        .eoi_en     (eoi_en_w),
        .eoi_lvl    (eoi_lvl_w),
        .take       (take_w),
        .take_lvl   (win_lvl_w),
        .irr        (irr_w),
        .isr        (isr_w),
        .mask       (mask_w)
    );

endmodule

// File: rtl/intc8_chk.sv
module intc8_chk #(
    parameter int N  = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          addr,
    input logic          wr,
    input logic          rd,
    input logic [DW-1:0] din,
    input logic          ack,
    input logic          int_out,
    input logic          ready,
    input logic          aeoi,
    input logic [N-1:0]  irr,
    input logic [N-1:0]  isr,
    input logic [N-1:0]  mask
);

    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !addr && din[4]) |=> !int_out); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !int_out); // R1

    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~mask) != '0)); // R6

    AST_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_out && !aeoi && !wr) |=> ($countones(isr) == $past($countones(isr)) + 1)); // R5

    AST_AEOI_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && aeoi && !wr) |=> $stable(isr)); // R5

    AST_SPEC_EOI: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr && !addr && din[6:3] == 4'b1100 && !ack && !rd) |=> !isr[$past(din[2:0])]); // R7

endmodule

bind intc8 intc8_chk #(.N(N), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr      (wr),
    .rd      (rd),
    .din     (din),
    .ack     (ack),
    .int_out (int_out),
    .ready   (ready_w),
    .aeoi    (auto_eoi_w),
    .irr     (irr_w),
    .isr     (isr_w),
    .mask    (mask_w)
);

// File: tb/intc8_test.sv
module intc8_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr = 1'b0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic [7:0] req_in = '0;
    logic       int_out;
    logic       ack = 1'b0;
    logic [7:0] vec;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    intc8 uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr      (wr),
        .rd      (rd),
        .din     (din),
        .dout    (dout),
        .req_in  (req_in),
        .int_out (int_out),
        .ack     (ack),
        .vec     (vec)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wreg(input logic a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(input logic a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = dout;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic do_ack(output logic [7:0] v);
        @(negedge clk);
        ack = 1'b1;
        #1 v = vec;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic int lowest(input logic [7:0] v);
        for (int i = 0; i < 8; i++)
            if (v[i]) return i;
        return 7;
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R1 reset int_out", {7'b0, int_out}, 8'h00);
        #1 check("R3 reset vec idle", vec, 8'h07);
        rreg(1'b1, v); check("R1 reset mask", v, 8'h00);

        // before any initialization
        req_in = 8'hFF;
        wreg(1'b1, 8'hFF);
        rreg(1'b1, v); check("R1 mask write ignored before init", v, 8'h00);
        settle(); check("R1 no interrupt before init", {7'b0, int_out}, 8'h00);
        req_in = 8'h00; settle();

        // full sequence: edge, cascade, options word present
        wreg(1'b0, 8'h11);
        wreg(1'b1, 8'h40);
        req_in = 8'h04; settle();
        wreg(1'b1, 8'h00);
        check("R2 quiet before options word", {7'b0, int_out}, 8'h00);
        wreg(1'b1, 8'h00);
        check("R2 active after options word", {7'b0, int_out}, 8'h01);
        do_ack(v); check("R2 vector after sequence", v, 8'h42);
        wreg(1'b1, 8'h5A);
        rreg(1'b1, v); check("R2 mask now writable", v, 8'h5A);
        req_in = 8'h00; settle();

        // level, single, auto-EOI, base A8: exhaustive request sweep
        wreg(1'b0, 8'h1B);
        wreg(1'b1, 8'hA8);
        wreg(1'b1, 8'h02);
        for (int p = 0; p < 256; p++) begin
            req_in = p[7:0];
            settle();
            check("R4 int_out for pattern", {7'b0, int_out}, (p != 0) ? 8'h01 : 8'h00);
            if (p != 0) begin
                do_ack(v);
                check("R3 R4 vector for pattern", v, 8'hA8 | 8'(lowest(p[7:0])));
            end
        end
        wreg(1'b0, 8'h0B);
        rreg(1'b0, v); check("R5 auto-EOI leaves in-service empty", v, 8'h00);

        // mask sweep with every input requesting
        req_in = 8'hFF;
        for (int m = 0; m < 256; m++) begin
            wreg(1'b1, m[7:0]);
            check("R6 int_out under mask", {7'b0, int_out}, (m != 255) ? 8'h01 : 8'h00);
            rreg(1'b1, v); check("R6 mask readback", v, m[7:0]);
            do_ack(v);
            check("R6 R3 vector under mask", v,
                  (m != 255) ? (8'hA8 | 8'(lowest(~m[7:0]))) : 8'hAF);
        end

        // edge mode, in-service held: nesting and end-of-interrupt
        req_in = 8'h00; settle();
        wreg(1'b0, 8'h13);
        wreg(1'b1, 8'h20);
        wreg(1'b1, 8'h00);
        req_in = 8'h20; settle();
        check("R8 edge raises interrupt", {7'b0, int_out}, 8'h01);
        do_ack(v); check("R3 vector level 5", v, 8'h25);
        check("R8 latch cleared by ack", {7'b0, int_out}, 8'h00);
        wreg(1'b0, 8'h0B);
        rreg(1'b0, v); check("R5 R9 in-service after ack", v, 8'h20);
        req_in = 8'h60; settle();
        check("R4 lower level blocked by in-service", {7'b0, int_out}, 8'h00);
        req_in = 8'h68; settle();
        check("R4 higher level nests", {7'b0, int_out}, 8'h01);
        do_ack(v); check("R3 vector level 3", v, 8'h23);
        rreg(1'b0, v); check("R5 two levels in service", v, 8'h28);
        wreg(1'b0, 8'h20);
        rreg(1'b0, v); check("R7 non-specific clears level 3", v, 8'h20);
        check("R4 level 6 still blocked", {7'b0, int_out}, 8'h00);
        wreg(1'b0, 8'h65);
        rreg(1'b0, v); check("R7 specific clears level 5", v, 8'h00);
        check("R4 level 6 now wins", {7'b0, int_out}, 8'h01);
        wreg(1'b0, 8'h0A);
        rreg(1'b0, v); check("R8 R9 request register", v, 8'h40);
        do_ack(v); check("R3 vector level 6", v, 8'h26);
        rreg(1'b0, v); check("R8 held input not re-latched", v, 8'h00);
        wreg(1'b0, 8'h0B);
        wreg(1'b0, 8'h05);
        rreg(1'b0, v); check("R7 bit 5 clear has no effect", v, 8'h40);
        wreg(1'b0, 8'h66);
        rreg(1'b0, v); check("R7 specific clears level 6", v, 8'h00);

        // poll
        req_in = 8'h00; settle();
        req_in = 8'h10; settle();
        wreg(1'b0, 8'h0C);
        rreg(1'b0, v); check("R10 poll result", v, 8'h84);
        rreg(1'b0, v); check("R10 poll accepted level 4", v, 8'h10);
        check("R10 interrupt dropped after poll", {7'b0, int_out}, 8'h00);
        wreg(1'b0, 8'h64);
        wreg(1'b0, 8'h0C);
        rreg(1'b0, v); check("R10 poll with nothing pending", v, 8'h00);

        // level mode, in-service held
        req_in = 8'h00; settle();
        wreg(1'b0, 8'h1A);
        wreg(1'b1, 8'h00);
        req_in = 8'h01; settle();
        check("R8 level raises interrupt", {7'b0, int_out}, 8'h01);
        do_ack(v); check("R3 vector level 0", v, 8'h00);
        check("R4 same level blocked by itself", {7'b0, int_out}, 8'h00);
        do_ack(v); check("R3 idle ack vector", v, 8'h07);
        wreg(1'b0, 8'h0A);
        rreg(1'b0, v); check("R8 level request follows input", v, 8'h01);
        req_in = 8'h00; settle();
        rreg(1'b0, v); check("R8 level request drops", v, 8'h00);
        wreg(1'b0, 8'h0B);
        rreg(1'b0, v); check("R9 select in-service", v, 8'h01);
        wreg(1'b0, 8'h08);
        rreg(1'b0, v); check("R9 bit 1 clear keeps selection", v, 8'h01);

        // restart while operational
        wreg(1'b1, 8'hF0);
        req_in = 8'h04;
        wreg(1'b0, 8'h1B);
        check("R1 quiet after restart", {7'b0, int_out}, 8'h00);
        rreg(1'b1, v); check("R1 mask cleared", v, 8'h00);
        wreg(1'b0, 8'h0B);
        wreg(1'b1, 8'h30);
        wreg(1'b1, 8'h00);
        rreg(1'b0, v); check("R1 read selection reset, command ignored", v, 8'h04);
        wreg(1'b0, 8'h0B);
        rreg(1'b0, v); check("R1 in-service cleared", v, 8'h00);
        do_ack(v); check("R3 vector after restart", v, 8'h32);

        finish_run();
    end

endmodule